// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block turns one input clock into the clock-line waveform and the data-line change points that an I2C master needs. It receives bus-level requests from a transfer sequencer: start, data bit or stop. It drives two open-drain style pull-down enables, one for SCL and one for SDA. It also returns one-cycle strobes that mark where SDA changes, where SDA should be sampled and where each bit slot ends. A request that arrives while the bus is already held becomes a repeated start, which uses its own waveform.

The phase lengths come from a 32-bit divisor word that software computes: a low-phase divisor and a high-phase divisor. Each divisor step lasts a fixed number of input clocks (eight by default), and the hardware adds one step to each divisor. Between requests the generator parks with SCL held low and SDA held at its last level. After a stop it returns to the released, idle bus.

Top module: `scl_tg`

## Requirements
- R1: `div_cfg[15:0]` is the low divisor and `div_cfg[31:16]` is the high divisor. The generator samples the field it needs only at the first edge of each phase. A change made in the middle of a phase therefore affects only later phases.
- R2: Each SCL low phase of a bit, repeated start or stop lasts (low+1)*8 clocks, with `scl_oe`=1.
- R3: The SCL high phase of a data bit lasts (high+1)*8 clocks, with `scl_oe`=0.
- R4: In a low phase, `sda_oe` takes its new value in cycle (low+1)*4, counted from 0. `sda_chg` pulses in that same cycle. For a data bit the new value is `sda_oe`=1 when the bit is 0. Every change of `sda_oe` comes with an `sda_chg` pulse.
- R5: In the high phase of a data bit, `sda_smp` pulses in cycle (high+1)*4 and `bit_done` pulses in the last cycle. Neither strobe ever occurs while `scl_oe`=1, and no two of the three strobes occur together.
- R6: A START from idle sets `sda_oe`=1 with SCL released for (high+1)*8 clocks, with `sda_chg` in the first of those cycles. The generator then parks with SCL low.
- R7: A START while parked is a repeated start. Its low phase releases SDA at the midpoint. SCL is then released for 2*(high+1)*8 clocks, and SDA is pulled low in cycle 7*(high+1) of that window, with an `sda_chg` pulse.
- R8: A STOP pulls SDA low at the low-phase midpoint. It then releases SCL for (high+1)*8 clocks, then releases SDA with an `sda_chg` pulse, and returns to idle.
- R9: `cmd_kind` is encoded as 0=START, 1=BIT, 2=STOP and 3=no operation. A request is taken on a clock edge where `cmd_valid` and `cmd_ready` are both 1. When the bus is idle, only START has an effect. BIT, STOP and code 3 leave both lines released. Code 3 has no effect while parked either.
- R10: While reset is held and after it is released, the generator is idle. Both enables are 0, no strobe is active and `cmd_ready`=1.
- R11: While parked, `scl_oe`=1, `sda_oe` holds its last value and `cmd_ready`=1. `cmd_ready` is 0 throughout every timed phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_cfg | input | 32 | High divisor [31:16], low divisor [15:0] |
| cmd_valid | input | 1 | Request present |
| cmd_kind | input | 2 | Request code (0 start, 1 bit, 2 stop, 3 none) |
| cmd_bit | input | 1 | Data bit value for a BIT request |
| cmd_ready | output | 1 | Generator idle or parked; a request can be taken |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| sda_chg | output | 1 | One-cycle mark: SDA changes in this cycle |
| sda_smp | output | 1 | One-cycle mark: sample SDA now |
| bit_done | output | 1 | One-cycle mark: last cycle of a data bit |

## Verification
The bench uses divisors of zero, where each phase has only eight clocks and the midpoint sits four cycles in. An off-by-one in the midpoint or end decode would show up there as an SDA change or sample strobe one cycle early or late. It issues repeated starts and checks the doubled high window and the 7/8 pull point. A design that reused the plain high length, or the midpoint, would release SCL early or move SDA at the wrong place. It rewrites the divisor in the middle of a phase to catch a design that stretches or cuts a running phase. It also issues BIT, STOP and no-operation codes on an idle bus and while parked, to catch a design that leaves idle without a START.

// File: rtl/scl_tg_pkg.sv
package scl_tg_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_STHI,
      PH_PARK,
      PH_LOW,
      PH_BITHI,
      PH_RSHI,
      PH_STPHI
   } ph_t;

   typedef enum logic [1:0] {
      OP_START = 2'd0,
      OP_BIT   = 2'd1,
      OP_STOP  = 2'd2,
      OP_NONE  = 2'd3
   } op_t;

endpackage

// File: rtl/scl_tg_cnt.sv
// Phase counter: captures a divisor at phase entry and counts clocks since.
module scl_tg_cnt #(
   parameter int DIVW = 16,
   parameter int CNTW = 20
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [DIVW-1:0] dnew,
   output logic [DIVW-1:0] dq,
   output logic [CNTW-1:0] elap
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dq   <= '0;
         elap <= '0;
      end else if (load) begin
         dq   <= dnew;
         elap <= '0;
      end else begin
         elap <= elap + 1'b1;
      end
   end

endmodule

// File: rtl/scl_tg_marks.sv
// Decodes the phase landmarks from the captured divisor and elapsed count.
module scl_tg_marks #(
   parameter int DIVW     = 16,
   parameter int STEP_LOG = 3,
   parameter int CNTW     = 20
) (
   input  logic [DIVW-1:0] dq,
   input  logic [CNTW-1:0] elap,
   output logic            at_mid_m1,
   output logic            at_end,
   output logic            at_end2,
   output logic            at_rs_m1
);

   localparam logic [CNTW-1:0] ONE   = CNTW'(1);
   localparam logic [CNTW-1:0] SEVEN = CNTW'(7);

   logic [CNTW-1:0] base;
   logic [CNTW-1:0] mid_m1, end_m1, end2_m1, rs_m1;

   always_comb begin
      base    = CNTW'(dq) + ONE;
      mid_m1  = (base << (STEP_LOG - 1)) - ONE;
      end_m1  = (base << STEP_LOG) - ONE;
      end2_m1 = (base << (STEP_LOG + 1)) - ONE;
      rs_m1   = ((base * SEVEN) << (STEP_LOG - 3)) - ONE;
   end

   assign at_mid_m1 = (elap == mid_m1);
   assign at_end    = (elap == end_m1);
   assign at_end2   = (elap == end2_m1);
   assign at_rs_m1  = (elap == rs_m1);

endmodule

// File: rtl/scl_tg.sv
module scl_tg
   import scl_tg_pkg::*;
#(
   parameter int DIVW     = 16,
   parameter int STEP_LOG = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2*DIVW-1:0] div_cfg,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_kind,
   input  logic              cmd_bit,
   output logic              cmd_ready,
   output logic              scl_oe,
   output logic              sda_oe,
   output logic              sda_chg,
   output logic              sda_smp,
   output logic              bit_done
);

   localparam int CNTW = DIVW + STEP_LOG + 1;

   generate
      if (STEP_LOG < 3 || DIVW < 1) begin : g_bad_cfg
         $error("scl_tg: STEP_LOG must be at least 3 and DIVW at least 1");
      end
   endgenerate

   ph_t             ph, ph_n;
   op_t             lop, lop_n, kind;
   logic            sda_q, sda_n, chg_q, chg_n, smp_q, smp_n;
   logic            lo_new, new_n;
   logic            ld, ld_hi;
   logic [DIVW-1:0] dnew, dq;
   logic [CNTW-1:0] elap;
   logic            at_mid_m1, at_end, at_end2, at_rs_m1;

   assign kind = op_t'(cmd_kind);
   assign dnew = ld_hi ? div_cfg[2*DIVW-1:DIVW] : div_cfg[DIVW-1:0];

   scl_tg_cnt #(.DIVW(DIVW), .CNTW(CNTW)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .load (ld),
      .dnew (dnew),
      .dq   (dq),
      .elap (elap)
   );

   scl_tg_marks #(.DIVW(DIVW), .STEP_LOG(STEP_LOG), .CNTW(CNTW)) u_marks (
      .dq       (dq),
      .elap     (elap),
      .at_mid_m1(at_mid_m1),
      .at_end   (at_end),
      .at_end2  (at_end2),
      .at_rs_m1 (at_rs_m1)
   );

   always_comb begin
      ph_n  = ph;
      sda_n = sda_q;
      chg_n = 1'b0;
      smp_n = 1'b0;
      ld    = 1'b0;
      ld_hi = 1'b0;
      lop_n = lop;
      new_n = lo_new;
      case (ph)
         PH_IDLE: begin
            if (cmd_valid && kind == OP_START) begin
               ph_n  = PH_STHI;
               ld    = 1'b1;
               ld_hi = 1'b1;
               sda_n = 1'b1;
               chg_n = 1'b1;
            end
         end
         PH_STHI: begin
            if (at_end) ph_n = PH_PARK;
         end
         PH_PARK: begin
            if (cmd_valid && kind != OP_NONE) begin
               ph_n  = PH_LOW;
               ld    = 1'b1;
               lop_n = kind;
               case (kind)
                  OP_START: new_n = 1'b0;
                  OP_STOP:  new_n = 1'b1;
                  default:  new_n = ~cmd_bit;
               endcase
            end
         end
         PH_LOW: begin
            if (at_mid_m1) begin
               sda_n = lo_new;
               chg_n = 1'b1;
            end
            if (at_end) begin
               ld    = 1'b1;
               ld_hi = 1'b1;
               case (lop)
                  OP_START: ph_n = PH_RSHI;
                  OP_STOP:  ph_n = PH_STPHI;
                  default:  ph_n = PH_BITHI;
               endcase
            end
         end
         PH_BITHI: begin
            smp_n = at_mid_m1;
            if (at_end) ph_n = PH_PARK;
         end
         PH_RSHI: begin
            if (at_rs_m1) begin
               sda_n = 1'b1;
               chg_n = 1'b1;
            end
            if (at_end2) ph_n = PH_PARK;
         end
         PH_STPHI: begin
            if (at_end) begin
               ph_n  = PH_IDLE;
               sda_n = 1'b0;
               chg_n = 1'b1;
            end
         end
         default: ph_n = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph     <= PH_IDLE;
         lop    <= OP_NONE;
         sda_q  <= 1'b0;
         chg_q  <= 1'b0;
         smp_q  <= 1'b0;
         lo_new <= 1'b0;
      end else begin
         ph     <= ph_n;
         lop    <= lop_n;
         sda_q  <= sda_n;
         chg_q  <= chg_n;
         smp_q  <= smp_n;
         lo_new <= new_n;
      end
   end

   assign cmd_ready = (ph == PH_IDLE) || (ph == PH_PARK);
   assign scl_oe    = (ph == PH_PARK) || (ph == PH_LOW);
   assign sda_oe    = sda_q;
   assign sda_chg   = chg_q;
   assign sda_smp   = smp_q;
   assign bit_done  = (ph == PH_BITHI) && at_end;

endmodule

// File: rtl/scl_tg_chk.sv
module scl_tg_chk (
   input logic clk,
   input logic rst_n,
   input logic cmd_ready,
   input logic scl_oe,
   input logic sda_oe,
   input logic sda_chg,
   input logic sda_smp,
   input logic bit_done
);

   // R5
   done_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_done |-> !scl_oe);

   // R5
   smp_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sda_smp |-> !scl_oe);

   // R5
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sda_chg, sda_smp, bit_done}));

   // R4
   sda_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> sda_chg);

   // R11
   park_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_done |=> (scl_oe && cmd_ready));

endmodule

bind scl_tg scl_tg_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cmd_ready(cmd_ready),
   .scl_oe   (scl_oe),
   .sda_oe   (sda_oe),
   .sda_chg  (sda_chg),
   .sda_smp  (sda_smp),
   .bit_done (bit_done)
);

// File: tb/scl_tg_test.sv
`timescale 1ns/1ps
module scl_tg_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] div_cfg = '0;
   logic        cmd_valid = 1'b0;
   logic [1:0]  cmd_kind = 2'd3;
   logic        cmd_bit = 1'b0;
   logic        cmd_ready, scl_oe, sda_oe, sda_chg, sda_smp, bit_done;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit live   = 0;

   always #2.5 clk = ~clk;

   scl_tg uut (
      .clk(clk), .rst_n(rst_n), .div_cfg(div_cfg), .cmd_valid(cmd_valid),
      .cmd_kind(cmd_kind), .cmd_bit(cmd_bit), .cmd_ready(cmd_ready),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_chg(sda_chg),
      .sda_smp(sda_smp), .bit_done(bit_done)
   );

   // Behavioural reference: phase codes 0 idle,1 start-high,2 park,3 low,
   // 4 bit-high,5 rs-high,6 stop-high
   int mph = 0, mt = 0, md = 0, mop = 3;
   bit mnew = 0, mold = 0, mpark = 0, mjust = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         mph = 0; mt = 0; md = 0; mjust = 0; mpark = 0;
      end else begin
         mjust = 0;
         case (mph)
            0: if (cmd_valid && cmd_kind == 2'd0) begin
                  mph = 1; mt = 0; md = int'(div_cfg[31:16]);
               end
            1: if (mt == 8*(md+1)-1) begin mph = 2; mpark = 1; end
               else mt++;
            2: if (cmd_valid && cmd_kind != 2'd3) begin
                  mph = 3; mt = 0; md = int'(div_cfg[15:0]);
                  mop = int'(cmd_kind); mold = mpark;
                  mnew = (cmd_kind == 2'd0) ? 1'b0 :
                         (cmd_kind == 2'd2) ? 1'b1 : !cmd_bit;
               end
            3: if (mt == 8*(md+1)-1) begin
                  mt = 0; md = int'(div_cfg[31:16]);
                  mph = (mop == 0) ? 5 : (mop == 2) ? 6 : 4;
               end else mt++;
            4: if (mt == 8*(md+1)-1) begin mph = 2; mpark = mnew; end
               else mt++;
            5: if (mt == 16*(md+1)-1) begin mph = 2; mpark = 1; end
               else mt++;
            6: if (mt == 8*(md+1)-1) begin mph = 0; mjust = 1; mpark = 0; end
               else mt++;
            default: mph = 0;
         endcase
      end
   end

   function automatic string tag_of(int ph, int d);
      if (ph == 3 && d != int'(div_cfg[15:0])) return "R1";
      if (ph >= 4 && d != int'(div_cfg[31:16])) return "R1";
      case (ph)
         0: return "R9";
         1: return "R6";
         2: return "R11";
         3: return "R2_R4";
         4: return "R3_R5";
         5: return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic chk(string req, string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (live) begin
         logic e_scl, e_sda, e_chg, e_smp, e_done, e_rdy;
         string tg;
         e_scl = (mph == 2 || mph == 3);
         e_rdy = (mph == 0 || mph == 2);
         e_chg = 0; e_smp = 0; e_done = 0;
         case (mph)
            0: begin e_sda = 0; e_chg = mjust; end
            1: begin e_sda = 1; e_chg = (mt == 0); end
            2: e_sda = mpark;
            3: begin e_sda = (mt >= 4*(md+1)) ? mnew : mold; e_chg = (mt == 4*(md+1)); end
            4: begin e_sda = mnew; e_smp = (mt == 4*(md+1)); e_done = (mt == 8*(md+1)-1); end
            5: begin e_sda = (mt >= 7*(md+1)); e_chg = (mt == 7*(md+1)); end
            default: e_sda = 1;
         endcase
         tg = tag_of(mph, md);
         chk(tg, "scl_oe", scl_oe, e_scl);
         chk(tg, "sda_oe", sda_oe, e_sda);
         chk(tg, "sda_chg", sda_chg, e_chg);
         chk(tg, "sda_smp", sda_smp, e_smp);
         chk(tg, "bit_done", bit_done, e_done);
         chk(tg, "cmd_ready", cmd_ready, e_rdy);
      end
   end

   task automatic issue(logic [1:0] k, logic b);
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      cmd_valid = 1; cmd_kind = k; cmd_bit = b;
      @(negedge clk);
      cmd_valid = 0; cmd_kind = 2'd3;
   endtask

   task automatic settle(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         fails++;
         $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      settle(3);
      // R10: reset state
      chk("R10", "scl_oe", scl_oe, 0);
      chk("R10", "sda_oe", sda_oe, 0);
      chk("R10", "strobes", sda_chg | sda_smp | bit_done, 0);
      chk("R10", "cmd_ready", cmd_ready, 1);
      rst_n = 1; live = 1;
      settle(2);

      div_cfg = {16'd1, 16'd2};
      issue(2'd0, 0); issue(2'd1, 1); issue(2'd1, 0); issue(2'd1, 1); issue(2'd2, 0);
      settle(40);

      // R9: requests other than START on an idle bus are ignored
      issue(2'd1, 0); issue(2'd2, 0); issue(2'd3, 0);
      settle(3);
      chk("R9", "idle scl_oe", scl_oe, 0);
      chk("R9", "idle sda_oe", sda_oe, 0);

      div_cfg = {16'd0, 16'd0};
      issue(2'd0, 0); issue(2'd1, 0); issue(2'd0, 0); issue(2'd1, 1);
      issue(2'd3, 0); settle(4);
      chk("R9", "park ignores code 3", scl_oe, 1);
      issue(2'd1, 0); issue(2'd2, 0);
      settle(30);

      // R1: divisor rewritten mid-phase
      div_cfg = {16'd3, 16'd5};
      issue(2'd0, 0); issue(2'd1, 0); issue(2'd1, 1);
      settle(5);
      div_cfg = {16'd6, 16'd1};
      issue(2'd0, 0); issue(2'd1, 1);
      settle(10);
      div_cfg = {16'd2, 16'd4};
      issue(2'd2, 0);
      settle(80);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule